// File: doc/BRIEF.md
# Single-Entry Posted Write Buffer

This block sits between a processor's write port and a shared system bus and gives a write-through cache the speed of posting. When the processor starts a memory write and the buffer is empty, the block latches the address, data, byte enables and cycle-type code into one holding entry. It ends the processor cycle in that same clock, with no wait states. It then runs the write on the system bus by itself, while the processor goes on. Every write reaches main memory. A write that the cache directory reports as a hit, and that is not marked non-cacheable, also drives a cache write strobe in the acceptance cycle.

Bus ownership follows a strap input. As bus master (strap low), a posted write waits while another master signals that it holds the bus, and starts once that signal drops. As bus slave (strap high), the block raises a hold request and starts once the grant is seen. A write can be posted while the bus belongs to someone else. The processor sees wait states only when it presents a new write while the earlier one has not yet completed. A processor read miss that needs the bus is held back while the entry is occupied, so that memory order is kept.

The sequencer has three states. ST_IDLE means the entry is empty. ST_ARB means the entry is full and the bus is not yet usable. ST_DRIVE means the bus write is running. The transitions are: ST_IDLE to ST_ARB on capture; ST_ARB to ST_DRIVE when the bus becomes usable (another master idle in master mode, grant high in slave mode); ST_DRIVE to ST_IDLE when the bus reports completion. In every other case the state holds.

Top module: `wpost_buffer`

## Requirements
- R1: After reset the entry is empty: sys_req and bus_hreq are low, and a read-miss request is let through at once (rdm_go high).
- R2: When cpu_wr_req is high and the entry is empty, cpu_ack is high in that same cycle, and the write is captured at the next clock edge.
- R3: While the entry holds a write, cpu_ack stays low for any new write request. The new write is acknowledged in the first cycle after the cycle in which sys_ready completed the earlier write.
- R4: While sys_req is high, sys_addr, sys_data, sys_be and sys_ctype equal the captured cpu_addr, cpu_data, cpu_be and cpu_ctype, and they stay stable until sys_ready.
- R5: In the acceptance cycle, cache_we is high exactly when dir_hit is high and cpu_noncache is low. cache_addr, cache_data and cache_be then equal cpu_addr, cpu_data and cpu_be. cache_we is low in all other cycles.
- R6: A non-cacheable write (cpu_noncache high) is still posted and run on the system bus, but never raises cache_we.
- R7: With slave_mode low (master mode), bus_hreq stays low and sys_req does not rise while other_busy is high. sys_req rises in the cycle after the first cycle in ST_ARB that sees other_busy low.
- R8: With slave_mode high, bus_hreq is high from the cycle after capture until the cycle after completion. sys_req rises in the cycle after the first cycle in ST_ARB that sees bus_grant high.
- R9: Each posted write produces exactly one bus write: sys_req falls in the cycle after sys_ready, and the entry is then empty.
- R10: rdm_go equals rdm_req while the entry is empty, and is low while the entry is occupied.
- R11: A write is acknowledged with no wait state even while another master holds the bus (other_busy high) or no grant has been given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slave_mode | input | 1 | Strap: 1 = request bus with hold/grant, 0 = master that waits for other master |
| cpu_wr_req | input | 1 | Processor memory write in progress |
| cpu_addr | input | AW | Processor write address |
| cpu_data | input | DW | Processor write data |
| cpu_be | input | DW/8 | Processor byte enables |
| cpu_ctype | input | CTW | Processor cycle-type code, carried to the bus unchanged |
| cpu_noncache | input | 1 | Decoded non-cacheable address |
| cpu_ack | output | 1 | Ends the processor write cycle |
| dir_hit | input | 1 | Directory hit for the current write address |
| cache_we | output | 1 | Cache data array write strobe |
| cache_addr | output | AW | Cache write address |
| cache_data | output | DW | Cache write data |
| cache_be | output | DW/8 | Cache byte enables |
| rdm_req | input | 1 | Processor read miss asks for the system bus |
| rdm_go | output | 1 | Read miss may start on the bus |
| other_busy | input | 1 | Master mode: another master holds the bus |
| bus_hreq | output | 1 | Slave mode: hold request |
| bus_grant | input | 1 | Slave mode: hold acknowledge |
| sys_req | output | 1 | System bus write cycle active |
| sys_addr | output | AW | System bus address |
| sys_data | output | DW | System bus write data |
| sys_be | output | DW/8 | System bus byte enables |
| sys_ctype | output | CTW | System bus cycle-type code |
| sys_ready | input | 1 | System bus write completes this cycle |

## Verification
The assertions take for granted that slave_mode is a strap that does not change while a write is in flight. They also assume that sys_ready is raised only while sys_req is high, and that in slave mode bus_grant stays high from the moment it is given until completion. The stimulus changes slave_mode only when the buffer is empty. It raises sys_ready only after it has seen sys_req high, and it holds bus_grant until the cycle after completion before dropping it.

// File: rtl/wpb_pkg.sv
package wpb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARB   = 2'd1,
        ST_DRIVE = 2'd2
    } wpb_state_e;
endpackage

// File: rtl/wpb_entry.sv
module wpb_entry #(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int CTW = 3,
    localparam int BEW = DW / 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           done,
    input  logic [AW-1:0]  in_addr,
    input  logic [DW-1:0]  in_data,
    input  logic [BEW-1:0] in_be,
    input  logic [CTW-1:0] in_ctype,
    output logic           valid,
    output logic [AW-1:0]  q_addr,
    output logic [DW-1:0]  q_data,
    output logic [BEW-1:0] q_be,
    output logic [CTW-1:0] q_ctype
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
        end else if (load) begin
            valid <= 1'b1;
        end else if (done) begin
            valid <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_addr  <= '0;
            q_data  <= '0;
            q_be    <= '0;
            q_ctype <= '0;
        end else if (load) begin
            q_addr  <= in_addr;
            q_data  <= in_data;
            q_be    <= in_be;
            q_ctype <= in_ctype;
        end
    end

    // A new capture must never overwrite a pending entry (R3)
    assert_no_overwrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !done |=> $stable(q_addr) && $stable(q_data));
endmodule

// File: rtl/wpb_seq.sv
module wpb_seq
    import wpb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic slave_mode,
    input  logic other_busy,
    input  logic bus_grant,
    input  logic sys_ready,
    output logic drive,
    output logic hreq,
    output logic done
);
    wpb_state_e state_q, state_d;
    logic       bus_usable;

    always_comb begin
        bus_usable = slave_mode ? bus_grant : !other_busy;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (load)       state_d = ST_ARB;
            ST_ARB:   if (bus_usable) state_d = ST_DRIVE;
            ST_DRIVE: if (sys_ready)  state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        drive = 1'b0;
        hreq  = 1'b0;
        done  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_ARB: begin
                hreq = slave_mode;
            end
            ST_DRIVE: begin
                drive = 1'b1;
                hreq  = slave_mode;
                done  = sys_ready;
            end
            default: begin
            end
        endcase
    end

    assert_master_waits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !slave_mode && other_busy && !drive |=> !drive);
    assert_master_no_hreq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !slave_mode |-> !hreq);
    assert_slave_waits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        slave_mode && !bus_grant && !drive |=> !drive);
    assert_single_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        drive && sys_ready |=> !drive);
    assert_capture_leaves_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> state_q == ST_ARB);
endmodule

// File: rtl/wpost_buffer.sv
module wpost_buffer #(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int CTW = 3,
    localparam int BEW = DW / 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           slave_mode,
    input  logic           cpu_wr_req,
    input  logic [AW-1:0]  cpu_addr,
    input  logic [DW-1:0]  cpu_data,
    input  logic [BEW-1:0] cpu_be,
    input  logic [CTW-1:0] cpu_ctype,
    input  logic           cpu_noncache,
    output logic           cpu_ack,
    input  logic           dir_hit,
    output logic           cache_we,
    output logic [AW-1:0]  cache_addr,
    output logic [DW-1:0]  cache_data,
    output logic [BEW-1:0] cache_be,
    input  logic           rdm_req,
    output logic           rdm_go,
    input  logic           other_busy,
    output logic           bus_hreq,
    input  logic           bus_grant,
    output logic           sys_req,
    output logic [AW-1:0]  sys_addr,
    output logic [DW-1:0]  sys_data,
    output logic [BEW-1:0] sys_be,
    output logic [CTW-1:0] sys_ctype,
    input  logic           sys_ready
);
    logic           occupied;
    logic           accept;
    logic           wr_done;
    logic           drive;
    logic [AW-1:0]  q_addr;
    logic [DW-1:0]  q_data;
    logic [BEW-1:0] q_be;
    logic [CTW-1:0] q_ctype;

    always_comb begin
        accept     = cpu_wr_req && !occupied;
        cpu_ack    = accept;
        cache_we   = accept && dir_hit && !cpu_noncache;
        cache_addr = cpu_addr;
        cache_data = cpu_data;
        cache_be   = cpu_be;
        rdm_go     = rdm_req && !occupied;
        sys_req    = drive;
        sys_addr   = q_addr;
        sys_data   = q_data;
        sys_be     = q_be;
        sys_ctype  = q_ctype;
    end

    wpb_entry #(.AW(AW), .DW(DW), .CTW(CTW)) u_entry (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .done     (wr_done),
        .in_addr  (cpu_addr),
        .in_data  (cpu_data),
        .in_be    (cpu_be),
        .in_ctype (cpu_ctype),
        .valid    (occupied),
        .q_addr   (q_addr),
        .q_data   (q_data),
        .q_be     (q_be),
        .q_ctype  (q_ctype)
    );

    wpb_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .slave_mode (slave_mode),
        .other_busy (other_busy),
        .bus_grant  (bus_grant),
        .sys_ready  (sys_ready),
        .drive      (drive),
        .hreq       (bus_hreq),
        .done       (wr_done)
    );

    assert_wait_while_draining_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sys_req && !sys_ready |=> !cpu_ack);
    assert_bus_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sys_req && !sys_ready |=> sys_req && $stable(sys_addr) && $stable(sys_data)
                                  && $stable(sys_be) && $stable(sys_ctype));
    assert_captured_on_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> $stable(sys_addr) || sys_addr == $past(cpu_addr));
    assert_nc_no_cache_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_noncache |-> !cache_we);
    assert_read_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sys_req |-> !rdm_go);
    assert_post_then_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !rdm_go);
endmodule

// File: tb/sim_wpost_buffer.sv
module sim_wpost_buffer;
    localparam int AW = 32, DW = 32, CTW = 3, BEW = DW / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic slave_mode = 0, cpu_wr_req = 0, cpu_noncache = 0, dir_hit = 0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_data = '0;
    logic [BEW-1:0] cpu_be = '0;
    logic [CTW-1:0] cpu_ctype = '0;
    logic rdm_req = 0, other_busy = 0, bus_grant = 0, sys_ready = 0;
    logic cpu_ack, cache_we, rdm_go, bus_hreq, sys_req;
    logic [AW-1:0] cache_addr, sys_addr;
    logic [DW-1:0] cache_data, sys_data;
    logic [BEW-1:0] cache_be, sys_be;
    logic [CTW-1:0] sys_ctype;

    wpost_buffer #(.AW(AW), .DW(DW), .CTW(CTW)) u0 (.*);

    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
        chk(act === exp, tag, act, exp);
    endtask

    typedef struct packed {
        logic          slave;
        logic          nc;
        logic          hit;
        logic [3:0]    waits;
        logic [31:0]   addr;
        logic [31:0]   data;
        logic [3:0]    be;
        logic [2:0]    ctype;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 1'b1, 4'd0, 32'h0000_1000, 32'hDEAD_BEEF, 4'hF, 3'd6},
        '{1'b0, 1'b0, 1'b0, 4'd3, 32'h0000_2004, 32'h1234_5678, 4'h3, 3'd7},
        '{1'b0, 1'b1, 1'b1, 4'd2, 32'hFFFF_FFFC, 32'hA5A5_5A5A, 4'hC, 3'd2},
        '{1'b1, 1'b0, 1'b1, 4'd0, 32'h8000_0010, 32'h0F0F_F0F0, 4'h1, 3'd6},
        '{1'b1, 1'b1, 1'b0, 4'd4, 32'h0000_0008, 32'hCAFE_0001, 4'h8, 3'd3},
        '{1'b1, 1'b0, 1'b0, 4'd1, 32'h0040_0000, 32'hFFFF_FFFF, 4'hF, 3'd1}
    };

    task automatic run_vec(input vec_t v);
        logic exp_we;
        exp_we = v.hit && !v.nc;
        @(negedge clk);
        slave_mode = v.slave;
        other_busy = !v.slave && (v.waits != 0);
        bus_grant = 0;
        cpu_wr_req = 1; cpu_addr = v.addr; cpu_data = v.data; cpu_be = v.be;
        cpu_ctype = v.ctype; cpu_noncache = v.nc; dir_hit = v.hit;
        #1;
        eq("R2/R11 ack with empty entry", cpu_ack, 1);
        eq("R5/R6 cache_we", cache_we, exp_we);
        if (exp_we) begin
            eq("R5 cache_addr", cache_addr, v.addr);
            eq("R5 cache_data", cache_data, v.data);
            eq("R5 cache_be", cache_be, v.be);
        end
        @(negedge clk);
        cpu_addr = ~v.addr; cpu_data = ~v.data; dir_hit = 1; cpu_noncache = 0;
        rdm_req = 1;
        #1;
        eq("R3 second write waits", cpu_ack, 0);
        eq("R5 no cache_we while waiting", cache_we, 0);
        eq("R10 read miss held", rdm_go, 0);
        cpu_wr_req = 0; rdm_req = 0;
        for (int k = 0; k < int'(v.waits); k++) begin
            eq("R7/R8 no bus cycle before bus usable", sys_req, 0);
            eq("R7/R8 hold request level", bus_hreq, v.slave);
            @(negedge clk);
        end
        other_busy = 0;
        bus_grant = v.slave;
        #1;
        eq("R7/R8 no bus cycle yet", sys_req, 0);
        eq("R8 hreq in arbitration", bus_hreq, v.slave);
        @(negedge clk);
        eq("R7/R8 bus cycle started", sys_req, 1);
        eq("R4 sys_addr", sys_addr, v.addr);
        eq("R4 sys_data", sys_data, v.data);
        eq("R4 sys_be", sys_be, v.be);
        eq("R4 sys_ctype", sys_ctype, v.ctype);
        eq("R6 non-cacheable still on bus", sys_req, 1);
        @(negedge clk);
        eq("R4 still driving", sys_req, 1);
        eq("R4 addr stable", sys_addr, v.addr);
        eq("R4 data stable", sys_data, v.data);
        sys_ready = 1;
        @(negedge clk);
        sys_ready = 0;
        rdm_req = 1;
        #1;
        eq("R9 single bus cycle", sys_req, 0);
        eq("R8 hreq dropped", bus_hreq, 0);
        eq("R10 read miss passes when empty", rdm_go, 1);
        rdm_req = 0;
        bus_grant = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        eq("R1 reset sys_req", sys_req, 0);
        eq("R1 reset hreq", bus_hreq, 0);
        rst_n = 1;
        @(negedge clk);
        rdm_req = 1;
        #1;
        eq("R1 rdm_go after reset", rdm_go, 1);
        eq("R1 no ack without request", cpu_ack, 0);
        eq("R1 sys_req idle", sys_req, 0);
        rdm_req = 0;

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // Directed: back-to-back writes, second waits until drain finishes (R3)
        @(negedge clk);
        slave_mode = 0; other_busy = 0;
        cpu_wr_req = 1; cpu_addr = 32'h100; cpu_data = 32'h11; cpu_be = 4'hF;
        cpu_ctype = 3'd6; dir_hit = 0; cpu_noncache = 0;
        #1 eq("R2 first write ack", cpu_ack, 1);
        @(negedge clk);
        cpu_addr = 32'h200; cpu_data = 32'h22;
        #1 eq("R3 waits in arbitration", cpu_ack, 0);
        @(negedge clk);
        #1 eq("R3 waits while driving", cpu_ack, 0);
        eq("R4 first address on bus", sys_addr, 32'h100);
        sys_ready = 1;
        #1 eq("R3 no ack in completion cycle", cpu_ack, 0);
        @(negedge clk);
        sys_ready = 0;
        #1 eq("R3 ack right after completion", cpu_ack, 1);
        @(negedge clk);
        cpu_wr_req = 0;
        @(negedge clk);
        eq("R9 second write on bus", sys_req, 1);
        eq("R4 second address", sys_addr, 32'h200);
        eq("R4 second data", sys_data, 32'h22);
        sys_ready = 1;
        @(negedge clk);
        sys_ready = 0;
        #1 eq("R9 bus idle after second", sys_req, 0);

        // Directed: posting while another master owns the bus, long hold (R11, R7)
        @(negedge clk);
        other_busy = 1;
        cpu_wr_req = 1; cpu_addr = 32'h300; cpu_data = 32'h33;
        #1 eq("R11 posted while bus busy", cpu_ack, 1);
        @(negedge clk);
        cpu_wr_req = 0;
        repeat (10) @(negedge clk);
        eq("R7 held off by other master", sys_req, 0);
        eq("R7 master mode never requests", bus_hreq, 0);
        other_busy = 0;
        @(negedge clk);
        eq("R7 starts after release", sys_req, 1);
        sys_ready = 1;
        @(negedge clk);
        sys_ready = 0;
        #1 eq("R9 done", sys_req, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule